// File: doc/BRIEF.md
# Two-Bank Programmable Pin Controller

This block drives sixteen general-purpose pins, grouped as two banks of eight. Each bank holds three configuration bytes that a configuration port writes: a direction mask, a polarity-invert mask and a drive-type mask that picks push-pull or open-drain. Software reaches the pin data through a 16-byte runtime window. The window can be moved anywhere in a 16-bit I/O space by setting its base, and it decodes only while its enable input is high.

The block computes output-enable and output-value for each pad from the stored data, polarity and drive type. Pad inputs pass through a two-flop synchroniser, are corrected for polarity, and can then be read. Reads return the level of every pin, outputs included. A data write only changes the stored value of pins that are set as outputs.

Top module: `pin_bank_io`

## Requirements
- R1: After a synchronous active-low reset, every configuration mask and every data latch is 0. All pins are inputs (pad_oe all 0) and pad_out is all 0.
- R2: Configuration writes land at these byte addresses: bank 0 direction 0x31, polarity 0x32, drive type 0x33; bank 1 direction 0x35, polarity 0x36, drive type 0x37. A write to any other address changes nothing.
- R3: A direction bit of 1 makes its pin an output. On a push-pull output (drive-type bit 0), pad_oe is 1 and pad_out equals the data bit XOR the polarity bit. A pin with direction bit 0 never has pad_oe set.
- R4: A drive-type bit of 1 selects open-drain. An open-drain output asserts pad_oe only when the data bit XOR the polarity bit is 0, and its pad_out is always 0.
- R5: The runtime window responds only when win_en is 1 and io_addr[15:4] equals win_base. Outside the window, reads return 0 and writes are ignored.
- R6: Inside the window, offset 0x0C holds bank 0 data and offset 0x0E holds bank 1 data. Any other offset reads 0 and ignores writes.
- R7: A data write updates only the latch bits whose direction bit is 1. Latch bits of input pins keep their value.
- R8: Reading a data register returns the synchronised pad level XOR the polarity bit for all eight pins of the bank, whatever their direction.
- R9: A change on pad_in shows up in read data after the second rising clock edge that follows it, and not after the first.
- R10: When a direction write and a data write to the same bank fall in the same cycle, the data write is masked by the direction that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| win_en | input | 1 | Runtime window decode enable |
| win_base | input | 12 | Runtime window base, compared with io_addr[15:4] |
| io_addr | input | 16 | Runtime I/O address |
| io_wr | input | 1 | Runtime write strobe |
| io_rd | input | 1 | Runtime read strobe |
| io_wdata | input | 8 | Runtime write data |
| io_rdata | output | 8 | Runtime read data, combinational, 0 when not selected |
| pad_in | input | 16 | Pad input levels, asynchronous |
| pad_oe | output | 16 | Pad driver enable per pin |
| pad_out | output | 16 | Pad output value per pin |

## Verification
A configuration write and a runtime data write can land on the same clock edge. This matters most when the configuration write changes the direction mask of the bank being written. The bench raises both strobes in one cycle, setting a bank's direction to all-output while writing all-ones to that bank's data. It then compares the pads against a model that masks the data with the direction that held before the edge, so pins that were inputs until that edge must keep their old latch value. The same per-cycle model also covers polarity being changed while reads are in progress, and pad changes crossing the synchroniser between two reads.

// File: rtl/pin_bank_pkg.sv
// Package: address constants shared by the pin controller and its checker.
// Assumes byte-wide configuration addresses and a 4-bit runtime offset.
package pin_bank_pkg;
    localparam int CFG_DIR_BASE   = 8'h31; // bank 0 direction address
    localparam int CFG_BANK_STEP  = 4;     // address step between banks
    localparam int DATA_OFF_BASE  = 4'hC;  // bank 0 data offset in window
    localparam int DATA_OFF_STEP  = 2;     // offset step between banks
endpackage

// File: rtl/pin_bank_cfg.sv
// Module: configuration masks of one bank (direction, polarity, drive type).
// Assumes one configuration write per cycle; unmatched addresses are ignored.
module pin_bank_cfg #(
    parameter int BANK_W   = 8,
    parameter int CFG_BASE = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [BANK_W-1:0] cfg_wdata,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] pol_q,
    output logic [BANK_W-1:0] odr_q
);
    localparam logic [7:0] A_DIR = 8'(CFG_BASE);
    localparam logic [7:0] A_POL = 8'(CFG_BASE + 1);
    localparam logic [7:0] A_ODR = 8'(CFG_BASE + 2);

    // Capture a configuration byte into the mask its address selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            pol_q <= '0;
            odr_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == A_DIR) dir_q <= cfg_wdata;
            if (cfg_addr == A_POL) pol_q <= cfg_wdata;
            if (cfg_addr == A_ODR) odr_q <= cfg_wdata;
        end
    end
endmodule

// File: rtl/pin_bank_sync.sv
// Module: two-flop synchroniser for the asynchronous pad inputs.
// Assumes each pin is sampled on its own; there is no bus coherence across pins.
module pin_bank_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Move pad levels through two flops before anything reads them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/pin_bank_data.sv
// Module: data latch and pad drive for one bank.
// Assumes wr_sel is already decoded; masks with the direction held before the edge.
module pin_bank_data #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] dir,
    input  logic [BANK_W-1:0] pol,
    input  logic [BANK_W-1:0] odr,
    output logic [BANK_W-1:0] dat_q,
    output logic [BANK_W-1:0] oe,
    output logic [BANK_W-1:0] out
);
    logic [BANK_W-1:0] drv;

    // Update only output pins' latch bits on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else if (wr_sel) begin
            dat_q <= (dat_q & ~dir) | (wdata & dir);
        end
    end

    // Derive per-pin driver enable and value from data, polarity and type.
    always_comb begin
        drv = dat_q ^ pol;
        for (int i = 0; i < BANK_W; i++) begin
            if (odr[i]) begin
                oe[i]  = dir[i] & ~drv[i];
                out[i] = 1'b0;
            end else begin
                oe[i]  = dir[i];
                out[i] = drv[i];
            end
        end
    end
endmodule

// File: rtl/pin_bank_io.sv
// Module: two-bank pin controller top; window decode, read mux, bank instances.
// Assumes io_rdata is sampled combinationally while io_rd is high.
module pin_bank_io
    import pin_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 16,
    parameter int WIN_LSB   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [7:0]                 cfg_addr,
    input  logic [BANK_W-1:0]          cfg_wdata,
    input  logic                       win_en,
    input  logic [ADDR_W-WIN_LSB-1:0]  win_base,
    input  logic [ADDR_W-1:0]          io_addr,
    input  logic                       io_wr,
    input  logic                       io_rd,
    input  logic [BANK_W-1:0]          io_wdata,
    output logic [BANK_W-1:0]          io_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
    output logic [NUM_BANKS*BANK_W-1:0] pad_oe,
    output logic [NUM_BANKS*BANK_W-1:0] pad_out
);
    localparam int PINS = NUM_BANKS * BANK_W;

    logic [PINS-1:0]      dir_all, pol_all, odr_all, dat_all, pin_sync;
    logic                 win_hit;
    logic [WIN_LSB-1:0]   win_off;
    logic [NUM_BANKS-1:0] bank_sel;

    // Decide whether the runtime address falls inside the enabled window.
    always_comb begin
        win_hit = win_en && (io_addr[ADDR_W-1:WIN_LSB] == win_base);
        win_off = io_addr[WIN_LSB-1:0];
    end

    pin_bank_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .d_sync  (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int OFF = DATA_OFF_BASE + b * DATA_OFF_STEP;

        // Select this bank when the window offset names its data register.
        assign bank_sel[b] = win_hit && (win_off == WIN_LSB'(OFF));

        pin_bank_cfg #(
            .BANK_W   (BANK_W),
            .CFG_BASE (CFG_DIR_BASE + b * CFG_BANK_STEP)
        ) u_cfg (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we),
            .cfg_addr  (cfg_addr),
            .cfg_wdata (cfg_wdata),
            .dir_q     (dir_all[b*BANK_W +: BANK_W]),
            .pol_q     (pol_all[b*BANK_W +: BANK_W]),
            .odr_q     (odr_all[b*BANK_W +: BANK_W])
        );

        pin_bank_data #(.BANK_W(BANK_W)) u_data (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (io_wr && bank_sel[b]),
            .wdata  (io_wdata),
            .dir    (dir_all[b*BANK_W +: BANK_W]),
            .pol    (pol_all[b*BANK_W +: BANK_W]),
            .odr    (odr_all[b*BANK_W +: BANK_W]),
            .dat_q  (dat_all[b*BANK_W +: BANK_W]),
            .oe     (pad_oe[b*BANK_W +: BANK_W]),
            .out    (pad_out[b*BANK_W +: BANK_W])
        );
    end

    // Return polarity-corrected synchronised levels of the selected bank.
    always_comb begin
        io_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (io_rd && bank_sel[b])
                io_rdata = io_rdata | (pin_sync[b*BANK_W +: BANK_W] ^ pol_all[b*BANK_W +: BANK_W]);
        end
    end
endmodule

// File: rtl/pin_bank_chk.sv
// Module: property checker for pin_bank_io, bound to every instance.
// Assumes at most one configuration write per cycle.
module pin_bank_chk #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter int PINS      = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [7:0]      cfg_addr,
    input logic            io_wr,
    input logic            io_rd,
    input logic            win_en,
    input logic [BANK_W-1:0] io_rdata,
    input logic [PINS-1:0] pad_oe,
    input logic [PINS-1:0] pad_out,
    input logic [PINS-1:0] dir_all,
    input logic [PINS-1:0] pol_all,
    input logic [PINS-1:0] odr_all,
    input logic [PINS-1:0] dat_all
);
    import pin_bank_pkg::*;

    logic cfg_mapped;

    // Flag configuration addresses that belong to some bank's masks.
    always_comb begin
        cfg_mapped = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            for (int f = 0; f < 3; f++)
                if (cfg_addr == 8'(CFG_DIR_BASE + b * CFG_BANK_STEP + f))
                    cfg_mapped = 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0) && (dat_all == '0));

    a_r2_unmapped_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_mapped) |=> $stable(dir_all) && $stable(pol_all) && $stable(odr_all));

    a_r3_oe_only_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_all) == '0);

    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & odr_all) == '0);

    a_r5_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_en && io_rd) |-> io_rdata == '0);

    a_r7_inputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> ((dat_all ^ $past(dat_all)) & ~$past(dir_all)) == '0);
endmodule

bind pin_bank_io pin_bank_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .PINS      (PINS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .win_en   (win_en),
    .io_rdata (io_rdata),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .dir_all  (dir_all),
    .pol_all  (pol_all),
    .odr_all  (odr_all),
    .dat_all  (dat_all)
);

// File: tb/pin_bank_io_bench.sv
// Bench: behavioural reference model compared each cycle, plus directed checks.
module pin_bank_io_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        win_en = 1'b0;
    logic [11:0] win_base = '0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe;
    logic [15:0] pad_out;

    int checks = 0;
    int errors = 0;

    // Reference model state (per-pin integer arrays, behavioural)
    int m_dir[16], m_pol[16], m_odr[16], m_dat[16];
    logic [15:0] sync_q[$];

    pin_bank_io u_pin_bank_io (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .win_en(win_en), .win_base(win_base),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sel_bank();
        if (!(win_en && io_addr[15:4] == win_base)) return -1;
        if (io_addr[3:0] == 4'hC) return 0;
        if (io_addr[3:0] == 4'hE) return 1;
        return -1;
    endfunction

    // Model next state on each rising edge, from the inputs held this cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_dir[i] = 0; m_pol[i] = 0; m_odr[i] = 0; m_dat[i] = 0;
            end
            sync_q = '{16'h0, 16'h0};
        end else begin
            int bk;
            bk = sel_bank();
            if (io_wr && bk >= 0)
                for (int i = 0; i < 8; i++)
                    if (m_dir[bk*8+i] == 1) m_dat[bk*8+i] = io_wdata[i];
            if (cfg_we)
                for (int b = 0; b < 2; b++)
                    for (int i = 0; i < 8; i++) begin
                        if (cfg_addr == 8'h31 + 4*b) m_dir[b*8+i] = cfg_wdata[i];
                        if (cfg_addr == 8'h32 + 4*b) m_pol[b*8+i] = cfg_wdata[i];
                        if (cfg_addr == 8'h33 + 4*b) m_odr[b*8+i] = cfg_wdata[i];
                    end
            sync_q.push_back(pad_in);
            void'(sync_q.pop_front());
        end
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] e_oe, e_out;
            logic [7:0]  e_rd;
            int bk, lvl;
            for (int i = 0; i < 16; i++) begin
                lvl = m_dat[i] ^ m_pol[i];
                if (m_dir[i] == 0) e_oe[i] = 1'b0;
                else if (m_odr[i] == 1) e_oe[i] = (lvl == 0);
                else e_oe[i] = 1'b1;
                e_out[i] = (m_odr[i] == 1) ? 1'b0 : lvl[0];
            end
            e_rd = '0;
            bk = sel_bank();
            if (io_rd && bk >= 0)
                for (int i = 0; i < 8; i++) e_rd[i] = sync_q[0][bk*8+i] ^ m_pol[bk*8+i][0];
            chk("R3 R4 pad_oe model", pad_oe, e_oe);
            chk("R3 R4 pad_out model", pad_out, e_out);
            chk("R8 io_rdata model", {8'h0, io_rdata}, {8'h0, e_rd});
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        tick();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        tick();
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] v);
        io_addr = a; io_rd = 1'b1;
        #1;
        v = io_rdata;
        io_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        win_en = 1'b1;
        win_base = 12'h1A0;
        tick();
        chk("R1 reset pad_oe", pad_oe, 16'h0000);
        chk("R1 reset pad_out", pad_out, 16'h0000);
        io_read(16'h1A0C, v);
        chk("R1 reset read", {8'h0, v}, 16'h0000);

        cfg_write(8'h31, 8'h0F);
        io_write(16'h1A0C, 8'hFF);
        chk("R3 R7 pp out", pad_out, 16'h000F);
        chk("R3 oe dir", pad_oe, 16'h000F);

        cfg_write(8'h32, 8'h03);
        chk("R3 polarity out", pad_out, 16'h000C);

        cfg_write(8'h33, 8'h0C);
        chk("R4 od oe", pad_oe, 16'h0003);
        chk("R4 od out", pad_out, 16'h0000);

        cfg_write(8'h35, 8'hF0);
        io_write(16'h1A0E, 8'hA5);
        chk("R2 R6 bank1 out", pad_out, 16'hA000);
        chk("R2 R7 bank1 oe", pad_oe, 16'hF003);

        io_write(16'h1B0C, 8'h00);
        chk("R5 base mismatch", pad_out, 16'hA000);
        win_en = 1'b0;
        io_write(16'h1A0E, 8'h00);
        chk("R5 window off write", pad_out, 16'hA000);
        io_read(16'h1A0E, v);
        chk("R5 window off read", {8'h0, v}, 16'h0000);
        win_en = 1'b1;
        io_write(16'h1A0D, 8'h00);
        chk("R6 bad offset write", pad_out, 16'hA000);

        tick();
        pad_in = 16'h5A3C;
        tick(); tick();
        io_read(16'h1A0C, v);
        chk("R8 bank0 read", {8'h0, v}, 16'h003F);
        io_read(16'h1A0E, v);
        chk("R8 bank1 read", {8'h0, v}, 16'h005A);
        io_read(16'h1A0D, v);
        chk("R6 bad offset read", {8'h0, v}, 16'h0000);

        pad_in = 16'h5A00;
        tick();
        io_read(16'h1A0C, v);
        chk("R9 one edge old", {8'h0, v}, 16'h003F);
        tick();
        io_read(16'h1A0C, v);
        chk("R9 two edges new", {8'h0, v}, 16'h0003);

        tick();
        cfg_we = 1'b1; cfg_addr = 8'h35; cfg_wdata = 8'hFF;
        io_wr = 1'b1; io_addr = 16'h1A0E; io_wdata = 8'hFF;
        tick();
        cfg_we = 1'b0; io_wr = 1'b0;
        chk("R10 same cycle out", pad_out, 16'hF000);
        chk("R10 same cycle oe", pad_oe, 16'hFF03);

        cfg_write(8'h34, 8'hFF);
        chk("R2 unmapped oe", pad_oe, 16'hFF03);
        chk("R2 unmapped out", pad_out, 16'hF000);

        repeat (3) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule